// File: doc/BRIEF.md
# Fractional Baud-Rate Generator

This block turns the system clock into a sampling tick that runs at sixteen times the serial bit rate, and into a one-per-bit enable for a serial transmitter. The rate is set by a divisor made of a 16-bit whole part and a 6-bit fraction counted in 64ths. The divisor is the clock frequency over sixteen times the baud rate. Software works out the divisor and writes it. The block only executes it.

The whole part, the fraction and an 8-bit line-control byte are written through separate strobes that share one data bus. Writes to the whole part and the fraction land in pending registers. A write to the line-control byte copies both pending parts into a 30-bit active setting, together with the new byte, and restarts the divider.

The divider counts whole clocks. A 6-bit accumulator adds the fraction once per tick period. Each carry out of the accumulator stretches that period by one clock, so the average period is the whole part plus the fraction over 64. A whole part of zero, or a low enable, stops both ticks.

Top module: `fracbaud_gen`

## Requirements
- R1: After reset the active whole part, fraction and line byte all read 0, and no tick is produced even with the enable high.
- R2: With whole part I >= 1 and fraction F, tick period k (k = 1 for the first after a restart) lasts I + floor(k*F/64) - floor((k-1)*F/64) clocks. Any 64 consecutive periods therefore last 64*I + F clocks, and at I >= 2 two ticks never fall on adjacent clocks.
- R3: Writes to the whole part (data bits 15:0) or the fraction (data bits 5:0) change neither the active outputs nor the tick timing until the line-control byte is written.
- R4: A line-control write commits the pending whole part, the pending fraction and data bits 7:0 to the active outputs on that clock edge. No tick appears in the following cycle, and the first tick of the new setting is seen I cycles after the committing edge.
- R5: While the enable is low or the active whole part is 0, no tick is produced. After the enable is sampled high, the first tick is seen I-1 cycles after that edge.
- R6: The bit enable pulses together with every sixteenth sampling tick, counted from the last restart, and never without a sampling tick.
- R7: All four update orders commit correctly: whole then fraction, fraction then whole, whole alone, and fraction alone. A part that is not rewritten keeps its previously pending value.
- R8: With a fraction of 0 every period is exactly I clocks, including I = 1, where the tick is high on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_int | input | 1 | Strobe: load pending whole part from wdata[15:0] |
| wr_frac | input | 1 | Strobe: load pending fraction from wdata[5:0] |
| wr_lcr | input | 1 | Strobe: commit the pending divisor and wdata[7:0] as line byte |
| wdata | input | 16 | Write data shared by the three strobes |
| enable | input | 1 | Runs the divider when high |
| tick16 | output | 1 | One-clock pulse at sixteen times the bit rate |
| bit_tick | output | 1 | One-clock pulse once per bit period |
| act_int | output | 16 | Active whole part of the divisor |
| act_frac | output | 6 | Active fraction of the divisor |
| act_lcr | output | 8 | Active line-control byte |

## Verification
Some properties can be checked on every cycle, and the assertions cover these. No tick is produced while the divider is idle. The bit enable never fires without a sampling tick. The active setting holds still unless a line-control write occurs. A commit loads the written line byte and suppresses the tick in the next cycle. A fractional carry coincides with a tick, and ticks are never adjacent at a whole part of two or more. The exact sequence of stretched periods, the 64-period total, the timing of the first tick after a commit or after the enable rises, and the position of the bit enable within the tick stream are shown only by the bench. It records the cycle of every tick and compares each one against the period formula.

// File: rtl/fracbaud_pkg.sv
package fracbaud_pkg;
  // Default geometry of the divisor and line-control settings.
  localparam int DEF_INT_W  = 16;
  localparam int DEF_FRAC_W = 6;
  localparam int DEF_LCR_W  = 8;
  localparam int DEF_OVS    = 16;

  // Selector used by the register block to pick the target of a write.
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_INT  = 2'd1,
    SEL_FRAC = 2'd2
  } pend_sel_e;
endpackage

// File: rtl/fracbaud_regs.sv
module fracbaud_regs
  import fracbaud_pkg::*;
#(
  parameter int INT_W  = DEF_INT_W,
  parameter int FRAC_W = DEF_FRAC_W,
  parameter int LCR_W  = DEF_LCR_W,
  parameter int DATA_W = DEF_INT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_int,
  input  logic              wr_frac,
  input  logic              wr_lcr,
  input  logic [DATA_W-1:0] wdata,
  output logic [INT_W-1:0]  act_int,
  output logic [FRAC_W-1:0] act_frac,
  output logic [LCR_W-1:0]  act_lcr,
  output logic              commit
);
  localparam int CFG_W = INT_W + FRAC_W + LCR_W;

  logic [INT_W-1:0]  pend_int_q;
  logic [FRAC_W-1:0] pend_frac_q;
  logic [CFG_W-1:0]  active_q;
  pend_sel_e         sel;

  // Pack the three fields into the single active word.
  function automatic logic [CFG_W-1:0] pack_cfg(
    input logic [INT_W-1:0]  iv,
    input logic [FRAC_W-1:0] fv,
    input logic [LCR_W-1:0]  lv
  );
    return {iv, fv, lv};
  endfunction

  always_comb begin
    if (wr_int)       sel = SEL_INT;
    else if (wr_frac) sel = SEL_FRAC;
    else              sel = SEL_NONE;
  end

  assign commit = wr_lcr;

  // Pending whole part.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_int_q <= '0;
    end else if (sel == SEL_INT) begin
      pend_int_q <= wdata[INT_W-1:0];
    end
  end

  // Pending fraction; a simultaneous whole-part write does not block it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_frac_q <= '0;
    end else if (wr_frac) begin
      pend_frac_q <= wdata[FRAC_W-1:0];
    end
  end

  // Active setting: loaded only by the line-control write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= '0;
    end else if (commit) begin
      active_q <= pack_cfg(pend_int_q, pend_frac_q, wdata[LCR_W-1:0]);
    end
  end

  assign act_int  = active_q[CFG_W-1 -: INT_W];
  assign act_frac = active_q[LCR_W +: FRAC_W];
  assign act_lcr  = active_q[LCR_W-1:0];
endmodule

// File: rtl/fracbaud_tickgen.sv
module fracbaud_tickgen
  import fracbaud_pkg::*;
#(
  parameter int INT_W  = DEF_INT_W,
  parameter int FRAC_W = DEF_FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              restart_req,
  input  logic [INT_W-1:0]  ival,
  input  logic [FRAC_W-1:0] fval,
  output logic              tick,
  output logic              carry_ev,
  output logic              restart_ev
);
  logic [INT_W-1:0]  cnt_q;
  logic [FRAC_W-1:0] acc_q;
  logic              restart_q;
  logic [FRAC_W:0]   step;

  // One fractional step: {carry, new accumulator}.
  function automatic logic [FRAC_W:0] frac_step(
    input logic [FRAC_W-1:0] acc,
    input logic [FRAC_W-1:0] f
  );
    return {1'b0, acc} + {1'b0, f};
  endfunction

  // Count loaded for a period: I clocks, plus one when stretched.
  function automatic logic [INT_W-1:0] period_load(
    input logic [INT_W-1:0] iv,
    input logic             stretch
  );
    return iv - INT_W'(1) + INT_W'(stretch);
  endfunction

  assign step       = frac_step(acc_q, fval);
  assign restart_ev = restart_q;
  assign tick       = run && !restart_q && (cnt_q == '0);
  assign carry_ev   = tick && step[FRAC_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      restart_q <= 1'b1;
    end else begin
      restart_q <= restart_req || !run;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (restart_q) begin
      // First period after a restart: accumulator starts at the fraction,
      // which cannot carry from zero.
      cnt_q <= period_load(ival, 1'b0);
      acc_q <= fval;
    end else if (tick) begin
      cnt_q <= period_load(ival, step[FRAC_W]);
      acc_q <= step[FRAC_W-1:0];
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - INT_W'(1);
    end
  end
endmodule

// File: rtl/fracbaud_bitdiv.sv
module fracbaud_bitdiv
  import fracbaud_pkg::*;
#(
  parameter int OVS = DEF_OVS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic tick16,
  output logic bit_tick
);
  generate
    if (OVS <= 1) begin : g_pass
      assign bit_tick = tick16;
    end else begin : g_count
      localparam int CW = $clog2(OVS);
      localparam logic [CW-1:0] LAST = CW'(OVS - 1);
      logic [CW-1:0] phase_q;

      function automatic logic [CW-1:0] next_phase(input logic [CW-1:0] p);
        return (p == LAST) ? '0 : p + CW'(1);
      endfunction

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          phase_q <= '0;
        end else if (restart) begin
          phase_q <= '0;
        end else if (tick16) begin
          phase_q <= next_phase(phase_q);
        end
      end

      assign bit_tick = tick16 && (phase_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/fracbaud_gen.sv
module fracbaud_gen
  import fracbaud_pkg::*;
#(
  parameter int INT_W  = DEF_INT_W,
  parameter int FRAC_W = DEF_FRAC_W,
  parameter int LCR_W  = DEF_LCR_W,
  parameter int OVS    = DEF_OVS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_int,
  input  logic              wr_frac,
  input  logic              wr_lcr,
  input  logic [INT_W-1:0]  wdata,
  input  logic              enable,
  output logic              tick16,
  output logic              bit_tick,
  output logic [INT_W-1:0]  act_int,
  output logic [FRAC_W-1:0] act_frac,
  output logic [LCR_W-1:0]  act_lcr
);
  // Named internal events, brought out for the checker.
  logic commit;
  logic run;
  logic frac_carry;
  logic restart_ev;

  fracbaud_regs #(
    .INT_W (INT_W),
    .FRAC_W(FRAC_W),
    .LCR_W (LCR_W),
    .DATA_W(INT_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_int  (wr_int),
    .wr_frac (wr_frac),
    .wr_lcr  (wr_lcr),
    .wdata   (wdata),
    .act_int (act_int),
    .act_frac(act_frac),
    .act_lcr (act_lcr),
    .commit  (commit)
  );

  assign run = enable && (act_int != '0);

  fracbaud_tickgen #(
    .INT_W (INT_W),
    .FRAC_W(FRAC_W)
  ) u_tick (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .restart_req(commit),
    .ival       (act_int),
    .fval       (act_frac),
    .tick       (tick16),
    .carry_ev   (frac_carry),
    .restart_ev (restart_ev)
  );

  fracbaud_bitdiv #(
    .OVS(OVS)
  ) u_bit (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart_ev),
    .tick16  (tick16),
    .bit_tick(bit_tick)
  );
endmodule

// File: rtl/fracbaud_chk.sv
module fracbaud_chk #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 6,
  parameter int LCR_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_lcr,
  input logic [INT_W-1:0]  wdata,
  input logic              enable,
  input logic              tick16,
  input logic              bit_tick,
  input logic [INT_W-1:0]  act_int,
  input logic [FRAC_W-1:0] act_frac,
  input logic [LCR_W-1:0]  act_lcr,
  input logic              frac_carry,
  input logic              restart_ev
);
  // R5: idle divider produces nothing.
  a_r5_idle_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable || act_int == '0) |-> !tick16);

  // R6: bit enable only together with a sampling tick.
  a_r6_bit_with_tick: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> tick16);

  // R3: active setting moves only on a line-control write.
  a_r3_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_lcr |=> $stable({act_int, act_frac, act_lcr}));

  // R4: commit loads the written line byte and restarts quietly.
  a_r4_commit_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lcr |=> (act_lcr == $past(wdata[LCR_W-1:0])));

  a_r4_commit_restart: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lcr |=> (restart_ev && !tick16));

  // R2: a stretch happens only at a period boundary; no adjacent ticks at I >= 2.
  a_r2_carry_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    frac_carry |-> tick16);

  a_r2_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick16 && act_int >= INT_W'(2) && !wr_lcr) |=> !tick16);
endmodule

bind fracbaud_gen fracbaud_chk #(
  .INT_W (INT_W),
  .FRAC_W(FRAC_W),
  .LCR_W (LCR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_lcr    (wr_lcr),
  .wdata     (wdata),
  .enable    (enable),
  .tick16    (tick16),
  .bit_tick  (bit_tick),
  .act_int   (act_int),
  .act_frac  (act_frac),
  .act_lcr   (act_lcr),
  .frac_carry(frac_carry),
  .restart_ev(restart_ev)
);

// File: tb/fracbaud_gen_tb.sv
module fracbaud_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_int = 1'b0, wr_frac = 1'b0, wr_lcr = 1'b0;
  logic [15:0] wdata = '0;
  logic        enable = 1'b0;
  logic        tick16, bit_tick;
  logic [15:0] act_int;
  logic [5:0]  act_frac;
  logic [7:0]  act_lcr;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int tt[4096];
  int nt = 0;
  int bt[1024];
  int nb = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fracbaud_gen u_dut (
    .clk(clk), .rst_n(rst_n), .wr_int(wr_int), .wr_frac(wr_frac),
    .wr_lcr(wr_lcr), .wdata(wdata), .enable(enable), .tick16(tick16),
    .bit_tick(bit_tick), .act_int(act_int), .act_frac(act_frac),
    .act_lcr(act_lcr)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (tick16 && nt < 4096) begin tt[nt] = cyc; nt++; end
    if (bit_tick && nb < 1024) begin bt[nb] = cyc; nb++; end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Drive one strobe for one clock; returns the cycle count after its edge.
  task automatic wr(input int sel, input logic [15:0] d, output int cc);
    @(negedge clk);
    wdata = d;
    wr_int  = (sel == 0);
    wr_frac = (sel == 1);
    wr_lcr  = (sel == 2);
    @(negedge clk);
    wr_int = 0; wr_frac = 0; wr_lcr = 0;
    cc = cyc;
  endtask

  function automatic int plen(input int i, input int f, input int k);
    return i + (k * f) / 64 - ((k - 1) * f) / 64;
  endfunction

  task automatic check_run(input string req, input int i, input int f,
                           input int base, input int bbase,
                           input int first_exp, input int n);
    int got = nt - base;
    int bad = 0;
    int bbad = 0;
    chk(got >= n, req, "tick count", got, n);
    if (got > n) got = n;
    if (got > 0) chk(tt[base] == first_exp, req, "first tick cycle", tt[base], first_exp);
    for (int k = 1; k < got; k++)
      if (tt[base+k] - tt[base+k-1] != plen(i, f, k + 1)) bad++;
    chk(bad == 0, req, "period mismatches", bad, 0);
    if (got >= 65)
      chk(tt[base+64] - tt[base] == 64 * i + f, "R2", "64-period span",
          tt[base+64] - tt[base], 64 * i + f);
    // R6: bit enable on every sixteenth tick since restart
    for (int m = 0; 16 * m + 15 < got; m++)
      if (bbase + m >= nb || bt[bbase+m] != tt[base+16*m+15]) bbad++;
    chk(bbad == 0, "R6", "bit tick misplaced", bbad, 0);
  endtask

  task automatic t_reset;
    chk(act_int == 0 && act_frac == 0 && act_lcr == 0, "R1", "active after reset",
        {act_int, act_frac, act_lcr}, 0);
    repeat (50) @(negedge clk);
    chk(nt == 0 && nb == 0, "R1", "ticks out of reset", nt, 0);
  endtask

  task automatic t_integer;
    int cc, b, bb;
    wr(0, 16'd4, cc);
    wr(2, 16'h00A5, cc);
    b = nt; bb = nb;
    chk(act_int == 4 && act_frac == 0 && act_lcr == 8'hA5, "R4", "committed setting",
        act_int, 4);
    repeat (64 * 4 + 20) @(negedge clk);
    check_run("R8", 4, 0, b, bb, cc + 4, 64);
    wr(0, 16'd1, cc);
    wr(2, 16'h0011, cc);
    b = nt; bb = nb;
    repeat (60) @(negedge clk);
    check_run("R8", 1, 0, b, bb, cc + 1, 48);
  endtask

  task automatic t_fraction_shadow;
    int cc, c2, b, bb;
    wr(0, 16'd3, cc);
    wr(1, 16'd21, cc);
    wr(2, 16'h0003, cc);
    b = nt; bb = nb;
    repeat (30) @(negedge clk);
    wr(0, 16'd7, c2);
    wr(1, 16'd5, c2);
    chk(act_int == 3 && act_frac == 21, "R3", "active moved by pending write",
        act_int, 3);
    repeat (140 * 4) @(negedge clk);
    check_run("R2", 3, 21, b, bb, cc + 3, 130);
    chk(act_int == 3 && act_frac == 21, "R3", "active still old",
        {act_int, act_frac}, {16'd3, 6'd21});
    wr(2, 16'h0007, cc);
    b = nt; bb = nb;
    chk(act_int == 7 && act_frac == 5 && act_lcr == 8'h07, "R4", "commit of pending",
        {act_int, act_frac}, {16'd7, 6'd5});
    repeat (70 * 8) @(negedge clk);
    check_run("R4", 7, 5, b, bb, cc + 7, 66);
  endtask

  task automatic t_sequences;
    int cc, b, bb;
    wr(1, 16'd9, cc);
    wr(0, 16'd2, cc);
    wr(2, 16'h0001, cc);
    b = nt; bb = nb;
    chk(act_int == 2 && act_frac == 9, "R7", "fraction then whole",
        {act_int, act_frac}, {16'd2, 6'd9});
    repeat (70 * 3) @(negedge clk);
    check_run("R7", 2, 9, b, bb, cc + 2, 66);
    wr(0, 16'd5, cc);
    wr(2, 16'h0002, cc);
    b = nt; bb = nb;
    chk(act_int == 5 && act_frac == 9, "R7", "whole alone keeps fraction",
        {act_int, act_frac}, {16'd5, 6'd9});
    repeat (40 * 6) @(negedge clk);
    check_run("R7", 5, 9, b, bb, cc + 5, 36);
    wr(1, 16'd63, cc);
    wr(2, 16'h0003, cc);
    b = nt; bb = nb;
    chk(act_int == 5 && act_frac == 63, "R7", "fraction alone keeps whole",
        {act_int, act_frac}, {16'd5, 6'd63});
    repeat (70 * 6) @(negedge clk);
    check_run("R7", 5, 63, b, bb, cc + 5, 66);
  endtask

  task automatic t_enable_zero;
    int cc, b, bb, e;
    wr(0, 16'd5, cc);
    wr(1, 16'd0, cc);
    wr(2, 16'h0000, cc);
    @(negedge clk);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    b = nt;
    repeat (100) @(negedge clk);
    chk(nt == b, "R5", "ticks while disabled", nt - b, 0);
    enable = 1'b1;
    @(negedge clk);
    e = cyc; b = nt; bb = nb;
    repeat (40 * 5) @(negedge clk);
    check_run("R5", 5, 0, b, bb, e + 4, 36);
    wr(0, 16'd0, cc);
    wr(2, 16'h0000, cc);
    b = nt;
    repeat (200) @(negedge clk);
    chk(nt == b, "R5", "ticks with whole part zero", nt - b, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    enable = 1'b1;
    @(negedge clk);
    t_reset();
    t_integer();
    t_fraction_shadow();
    t_sequences();
    t_enable_zero();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule